// File: doc/BRIEF.md
# SDRAM Command Decoder and Mode Register

This block is the control front end of a four-bank synchronous DRAM. On every rising clock edge it samples chip select, the row strobe, the column strobe, write enable, clock enable, the two bank-select bits and the shared address pins. It turns them into one of activate, read, write, precharge, auto refresh, self refresh or mode register set. It also keeps the programmable operating mode and records which row, if any, is open in each bank.

Accepted reads and writes go out as one-cycle requests carrying bank, open row and column. An internal burst counter keeps `burst_busy_o` high for the programmed burst length. Deselecting the chip blocks new commands but does not cut a running burst short. Commands that are illegal in the current bank state, and mode codes that are not supported, raise a one-cycle error pulse and change nothing else.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: While `cs_ni` is high at an edge, the command on the strobes is ignored: no bank, mode, request or error output changes because of it.
- R2: A burst already running keeps `burst_busy_o` high for its full length, even if the chip is deselected during it.
- R3: Activate ({ras,cas,we}=011) on a bank with no open row opens it and stores the 12-bit address as that bank's row. Activate on a bank that is already open raises `err_o` and leaves the bank unchanged.
- R4: Read (101) or write (100) on an open bank pulses `rd_req_o` or `wr_req_o` for one cycle, with the bank, the stored row and column `addr_i[7:0]`. The same command on a closed bank gives only an `err_o` pulse.
- R5: Precharge (010) with `addr_i[10]` high closes all banks. With `addr_i[10]` low it closes only the bank on `ba_i`. It never raises an error.
- R6: Mode register set (000) loads the following fields. Burst length comes from `addr_i[2:0]`: 000=1, 001=2, 010=4, 011=8, 111=full page of 256. Burst type comes from `addr_i[3]`: 1 means interleaved. CAS latency comes from `addr_i[6:4]`: 010=2, 011=3.
- R7: A mode register set with any other burst-length or latency code raises `err_o` and leaves the mode outputs unchanged.
- R8: Auto refresh (001, clock enable high) and mode register set are accepted only when no bank is open. Otherwise they raise `err_o`. An accepted auto refresh pulses `refresh_o` for one cycle.
- R9: `burst_busy_o` goes high in the cycle after an accepted read or write and stays high for exactly the programmed burst length in clock-enabled cycles. A new read or write restarts the count.
- R10: With `cke_i` low at an edge, no command other than self-refresh entry is accepted and the burst count is frozen. If no burst is running and self refresh is not entered, `pwr_dn_o` is high in the following cycle.
- R11: Refresh (001) with `cke_i` low, all banks closed and no burst running sets `self_ref_o`. If a bank is open or a burst is running, it raises `err_o` instead. `self_ref_o` clears at the first edge with `cke_i` high, and the command at that edge is ignored.
- R12: After reset all banks are closed, all rows are zero, no request or error is active, and the mode is burst length 1, sequential, CAS latency 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge samples all inputs |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select |
| addr_i | input | 12 | Multiplexed row/column/mode address |
| rd_req_o | output | 1 | Read request pulse to burst engine |
| wr_req_o | output | 1 | Write request pulse to burst engine |
| req_bank_o | output | 2 | Bank of the last request |
| req_row_o | output | 12 | Open row of the last request |
| req_col_o | output | 8 | Start column of the last request |
| refresh_o | output | 1 | Auto refresh accepted pulse |
| err_o | output | 1 | Illegal command pulse |
| bank_open_o | output | 4 | One bit per bank, high when a row is open |
| bank_rows_o | output | 48 | Open row of each bank, bank 0 in the low bits |
| cas_lat_o | output | 2 | Programmed CAS latency (2 or 3) |
| burst_len_o | output | 9 | Programmed burst length in beats |
| burst_ilv_o | output | 1 | Interleaved burst order selected |
| burst_busy_o | output | 1 | Burst in progress |
| self_ref_o | output | 1 | Self refresh active |
| pwr_dn_o | output | 1 | Power-down active |

## Verification
The hardest situations to reach are the ones where a burst overlaps other conditions. These are a full-page burst running through a long stretch of deselected cycles, a clock-enable drop in the middle of a burst, and a self-refresh request made while that burst is still running. The stimulus programs the mode register first, opens a bank, and starts a burst. It then holds deselect or lowers clock enable for a chosen number of cycles while the bench's model counts the remaining beats on every edge. This shows that the count freezes and resumes, and that self-refresh entry is refused with an error until the burst has drained.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_REF,
    CMD_MRS
  } cmd_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_cmd_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_NOP;
    if (!cs_ni) begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        3'b001:  cmd_o = CMD_REF;
        3'b000:  cmd_o = CMD_MRS;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg #(
  parameter int ROW_W = 12,
  parameter int COL_W = 8,
  localparam int LEN_W = COL_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ROW_W-1:0] addr_i,
  output logic             bad_o,
  output logic [1:0]       cas_lat_o,
  output logic [LEN_W-1:0] burst_len_o,
  output logic             burst_ilv_o
);
  logic [2:0] bl_code, cl_code;
  logic       bl_ok, cl_ok;

  assign bl_code = addr_i[2:0];
  assign cl_code = addr_i[6:4];
  assign bl_ok   = (bl_code == 3'b111) || (bl_code[2] == 1'b0);
  assign cl_ok   = (cl_code == 3'b010) || (cl_code == 3'b011);
  assign bad_o   = !(bl_ok && cl_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cas_lat_o   <= 2'd3;
      burst_len_o <= LEN_W'(1);
      burst_ilv_o <= 1'b0;
    end else if (load_i && !bad_o) begin
      cas_lat_o   <= cl_code[1:0];
      burst_len_o <= (bl_code == 3'b111) ? (LEN_W'(1) << COL_W)
                                         : (LEN_W'(1) << bl_code[1:0]);
      burst_ilv_o <= addr_i[3];
    end
  end

  p_bad_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && bad_o) |=> ($stable(cas_lat_o) && $stable(burst_len_o) && $stable(burst_ilv_o)));
  p_cl_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_lat_o == 2'd2) || (cas_lat_o == 2'd3));
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       act_i,
  input  logic                       pre_i,
  input  logic                       pre_all_i,
  input  logic [BA_W-1:0]            bank_i,
  input  logic [ROW_W-1:0]           row_i,
  output logic [NUM_BANKS-1:0]       open_o,
  output logic [NUM_BANKS*ROW_W-1:0] rows_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (bank_i == BA_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_o[b]                 <= 1'b0;
        rows_o[b*ROW_W +: ROW_W] <= '0;
      end else if (act_i && sel) begin
        open_o[b]                 <= 1'b1;
        rows_o[b*ROW_W +: ROW_W] <= row_i;
      end else if (pre_i && (pre_all_i || sel)) begin
        open_o[b] <= 1'b0;
      end
    end
  end

  p_pre_all_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_i && pre_all_i && !act_i) |=> (open_o == '0));
  p_act_opens_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> open_o[$past(bank_i)]);
endmodule

// File: rtl/sdram_burst_ctr.sv
module sdram_burst_ctr #(
  parameter int COL_W = 8,
  localparam int LEN_W = COL_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o
);
  logic [LEN_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    left_q <= '0;
    else if (start_i)               left_q <= len_i;
    else if (run_i && left_q != '0) left_q <= left_q - LEN_W'(1);
  end

  assign busy_o = (left_q != '0);

  p_suspend_freeze_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !start_i) |=> $stable(left_q));
endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 8,
  parameter int AP_BIT    = 10,
  localparam int BA_W     = $clog2(NUM_BANKS),
  localparam int LEN_W    = COL_W + 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cke_i,
  input  logic                       cs_ni,
  input  logic                       ras_ni,
  input  logic                       cas_ni,
  input  logic                       we_ni,
  input  logic [BA_W-1:0]            ba_i,
  input  logic [ROW_W-1:0]           addr_i,
  output logic                       rd_req_o,
  output logic                       wr_req_o,
  output logic [BA_W-1:0]            req_bank_o,
  output logic [ROW_W-1:0]           req_row_o,
  output logic [COL_W-1:0]           req_col_o,
  output logic                       refresh_o,
  output logic                       err_o,
  output logic [NUM_BANKS-1:0]       bank_open_o,
  output logic [NUM_BANKS*ROW_W-1:0] bank_rows_o,
  output logic [1:0]                 cas_lat_o,
  output logic [LEN_W-1:0]           burst_len_o,
  output logic                       burst_ilv_o,
  output logic                       burst_busy_o,
  output logic                       self_ref_o,
  output logic                       pwr_dn_o
);
  cmd_e cmd;
  logic live, all_idle, sel_open, mode_bad;
  logic act_hit, rw_hit, ref_hit, mrs_hit, sref_hit;
  logic act_ok, rw_ok, ref_ok, mrs_ok, sref_ok, err_d;

  sdram_cmd_decode u_dec (
    .cs_ni (cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni), .cmd_o(cmd)
  );

  // commands execute only with clock enabled and outside self refresh
  assign live     = cke_i && !self_ref_o;
  assign all_idle = (bank_open_o == '0);
  assign sel_open = bank_open_o[ba_i];

  assign act_hit  = live && (cmd == CMD_ACT);
  assign rw_hit   = live && (cmd == CMD_RD || cmd == CMD_WR);
  assign ref_hit  = live && (cmd == CMD_REF);
  assign mrs_hit  = live && (cmd == CMD_MRS);
  assign sref_hit = !cke_i && !self_ref_o && (cmd == CMD_REF);

  assign act_ok  = act_hit && !sel_open;
  assign rw_ok   = rw_hit && sel_open;
  assign ref_ok  = ref_hit && all_idle;
  assign mrs_ok  = mrs_hit && all_idle && !mode_bad;
  assign sref_ok = sref_hit && all_idle && !burst_busy_o;
  assign err_d   = (act_hit && !act_ok) || (rw_hit && !rw_ok) || (ref_hit && !ref_ok)
                || (mrs_hit && !mrs_ok) || (sref_hit && !sref_ok);

  sdram_mode_reg #(.ROW_W(ROW_W), .COL_W(COL_W)) u_mode (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(mrs_hit && all_idle), .addr_i(addr_i),
    .bad_o(mode_bad), .cas_lat_o(cas_lat_o), .burst_len_o(burst_len_o),
    .burst_ilv_o(burst_ilv_o)
  );

  sdram_bank_track #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_banks (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act_ok), .pre_i(live && cmd == CMD_PRE),
    .pre_all_i(addr_i[AP_BIT]), .bank_i(ba_i), .row_i(addr_i),
    .open_o(bank_open_o), .rows_o(bank_rows_o)
  );

  sdram_burst_ctr #(.COL_W(COL_W)) u_burst (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(rw_ok), .run_i(cke_i),
    .len_i(burst_len_o), .busy_o(burst_busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_req_o   <= 1'b0;
      wr_req_o   <= 1'b0;
      req_bank_o <= '0;
      req_row_o  <= '0;
      req_col_o  <= '0;
      refresh_o  <= 1'b0;
      err_o      <= 1'b0;
      self_ref_o <= 1'b0;
      pwr_dn_o   <= 1'b0;
    end else begin
      rd_req_o  <= rw_ok && (cmd == CMD_RD);
      wr_req_o  <= rw_ok && (cmd == CMD_WR);
      refresh_o <= ref_ok;
      err_o     <= err_d;
      if (rw_ok) begin
        req_bank_o <= ba_i;
        req_row_o  <= bank_rows_o[ba_i*ROW_W +: ROW_W];
        req_col_o  <= addr_i[COL_W-1:0];
      end
      if (self_ref_o) self_ref_o <= !cke_i;
      else            self_ref_o <= sref_ok;
      pwr_dn_o <= !cke_i && !self_ref_o && !sref_ok && !burst_busy_o;
    end
  end

  p_req_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((rd_req_o || wr_req_o) && err_o));
  p_deselect_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (!rd_req_o && !wr_req_o && !refresh_o && !err_o));
  p_sref_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(self_ref_o) |-> (bank_open_o == '0 && !burst_busy_o));
  p_ref_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_o |-> (bank_open_o == '0));
endmodule

// File: tb/sdram_cmd_ctrl_bench.sv
module sdram_cmd_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [11:0] addr = '0;
  logic rd_req, wr_req, refresh, err, burst_ilv, burst_busy, self_ref, pwr_dn;
  logic [1:0] req_bank, cas_lat;
  logic [11:0] req_row;
  logic [7:0] req_col;
  logic [3:0] bank_open;
  logic [47:0] bank_rows;
  logic [8:0] burst_len;

  int compared = 0, mismatched = 0;
  string cur_req = "R12";

  // reference model state
  int m_open[4], m_row[4], m_bl, m_cl, m_ilv, m_left, m_sref, m_pd;
  int m_rd, m_wr, m_bank, m_rrow, m_col, m_ref, m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_ctrl u_sdram_cmd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .addr_i(addr),
    .rd_req_o(rd_req), .wr_req_o(wr_req), .req_bank_o(req_bank), .req_row_o(req_row),
    .req_col_o(req_col), .refresh_o(refresh), .err_o(err), .bank_open_o(bank_open),
    .bank_rows_o(bank_rows), .cas_lat_o(cas_lat), .burst_len_o(burst_len),
    .burst_ilv_o(burst_ilv), .burst_busy_o(burst_busy), .self_ref_o(self_ref),
    .pwr_dn_o(pwr_dn)
  );

  task automatic chk(string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_row[b] = 0; end
    m_bl = 1; m_cl = 3; m_ilv = 0; m_left = 0; m_sref = 0; m_pd = 0;
    m_rd = 0; m_wr = 0; m_bank = 0; m_rrow = 0; m_col = 0; m_ref = 0; m_err = 0;
  endtask

  task automatic model_edge();
    int c, any_open, live, blc, clc, good, busy, sref_go;
    c = cs_n ? 7 : {ras_n, cas_n, we_n};
    any_open = 0;
    for (int b = 0; b < 4; b++) if (m_open[b] != 0) any_open = 1;
    busy = (m_left != 0);
    live = cke && !m_sref;
    m_rd = 0; m_wr = 0; m_ref = 0; m_err = 0; sref_go = 0;
    if (live) begin
      case (c)
        3: if (m_open[ba] != 0) m_err = 1; else begin m_open[ba] = 1; m_row[ba] = addr; end
        5, 4: if (m_open[ba] == 0) m_err = 1;
              else begin
                if (c == 5) m_rd = 1; else m_wr = 1;
                m_bank = ba; m_rrow = m_row[ba]; m_col = addr[7:0];
              end
        2: if (addr[10]) for (int b = 0; b < 4; b++) m_open[b] = 0; else m_open[ba] = 0;
        1: if (any_open) m_err = 1; else m_ref = 1;
        0: begin
             blc = addr[2:0]; clc = addr[6:4];
             good = (blc <= 3 || blc == 7) && (clc == 2 || clc == 3);
             if (any_open || !good) m_err = 1;
             else begin
               m_bl = (blc == 7) ? 256 : (1 << blc);
               m_cl = clc; m_ilv = addr[3];
             end
           end
        default: ;
      endcase
    end else if (!cke && !m_sref && c == 1) begin
      if (any_open || busy) m_err = 1; else sref_go = 1;
    end
    if (m_rd || m_wr) m_left = m_bl;
    else if (cke && m_left > 0) m_left--;
    m_pd = (!cke && !m_sref && !sref_go && !busy);
    if (m_sref) m_sref = !cke; else m_sref = sref_go;
  endtask

  task automatic compare_all();
    longint rows = 0;
    int opn = 0;
    for (int b = 0; b < 4; b++) begin
      rows |= longint'(m_row[b]) << (12*b);
      opn |= m_open[b] << b;
    end
    chk("rd_req", rd_req, m_rd);
    chk("wr_req", wr_req, m_wr);
    chk("req_bank", req_bank, m_bank);
    chk("req_row", req_row, m_rrow);
    chk("req_col", req_col, m_col);
    chk("refresh", refresh, m_ref);
    chk("err", err, m_err);
    chk("bank_open", bank_open, opn);
    chk("bank_rows", bank_rows, rows);
    chk("cas_lat", cas_lat, m_cl);
    chk("burst_len", burst_len, m_bl);
    chk("burst_ilv", burst_ilv, m_ilv);
    chk("burst_busy", burst_busy, m_left != 0);
    chk("self_ref", self_ref, m_sref);
    chk("pwr_dn", pwr_dn, m_pd);
  endtask

  // one edge: drive at negedge, model at posedge, compare at next negedge
  task automatic tick(logic k, logic s, logic [2:0] rcw, logic [1:0] b, logic [11:0] a,
                      string req);
    cur_req = req;
    cke = k; cs_n = s; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic cmd(logic [2:0] rcw, logic [1:0] b, logic [11:0] a, string req);
    tick(1'b1, 1'b0, rcw, b, a, req);
  endtask

  task automatic idle(int n, logic k, logic s, string req);
    for (int i = 0; i < n; i++) tick(k, s, 3'b111, 2'd0, 12'h000, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    cur_req = "R12";
    compare_all();
    rst_n = 1'b1;
    idle(2, 1'b1, 1'b0, "R12");
    // R3 activate and double activate
    cmd(3'b011, 2'd0, 12'h123, "R3");
    cmd(3'b011, 2'd0, 12'h456, "R3");
    // R1 deselected activate and read have no effect
    tick(1'b1, 1'b1, 3'b011, 2'd1, 12'h777, "R1");
    tick(1'b1, 1'b1, 3'b101, 2'd0, 12'h012, "R1");
    // R8 mode set and refresh with a bank open
    cmd(3'b000, 2'd0, 12'h022, "R8");
    cmd(3'b001, 2'd0, 12'h000, "R8");
    // R5 precharge all, then refresh accepted
    cmd(3'b010, 2'd3, 12'h400, "R5");
    cmd(3'b001, 2'd0, 12'h000, "R8");
    // R6 and R7 mode programming
    cmd(3'b000, 2'd0, 12'h022, "R6");
    cmd(3'b000, 2'd0, 12'h012, "R7");
    cmd(3'b000, 2'd0, 12'h024, "R7");
    cmd(3'b000, 2'd0, 12'h03B, "R6");
    // R4 requests and closed-bank access
    cmd(3'b100, 2'd1, 12'h010, "R4");
    cmd(3'b011, 2'd2, 12'hABC, "R4");
    cmd(3'b101, 2'd2, 12'h045, "R4");
    // R2 burst runs through deselect
    idle(9, 1'b1, 1'b1, "R2");
    // R5 single-bank precharge
    cmd(3'b011, 2'd1, 12'h3C3, "R5");
    cmd(3'b010, 2'd2, 12'h000, "R5");
    // R9 restart of a burst, R10 suspend mid-burst
    cmd(3'b100, 2'd1, 12'h0FE, "R9");
    idle(3, 1'b1, 1'b0, "R9");
    cmd(3'b101, 2'd1, 12'h001, "R9");
    idle(2, 1'b1, 1'b0, "R9");
    idle(4, 1'b0, 1'b0, "R10");
    tick(1'b0, 1'b0, 3'b011, 2'd3, 12'h111, "R10");
    tick(1'b0, 1'b0, 3'b001, 2'd0, 12'h000, "R11");
    idle(10, 1'b1, 1'b0, "R9");
    idle(3, 1'b0, 1'b0, "R10");
    // R11 entry refused while a bank is open
    tick(1'b0, 1'b0, 3'b001, 2'd0, 12'h000, "R11");
    // R9 full page burst
    cmd(3'b010, 2'd0, 12'h400, "R9");
    cmd(3'b000, 2'd0, 12'h037, "R6");
    cmd(3'b011, 2'd3, 12'hFFF, "R9");
    cmd(3'b100, 2'd3, 12'h0FF, "R9");
    idle(258, 1'b1, 1'b1, "R9");
    // R11 self refresh entry, stay, exit with ignored command
    cmd(3'b010, 2'd0, 12'h400, "R11");
    tick(1'b0, 1'b0, 3'b001, 2'd0, 12'h000, "R11");
    idle(5, 1'b0, 1'b0, "R11");
    cmd(3'b011, 2'd0, 12'h0AA, "R11");
    cmd(3'b011, 2'd0, 12'h0BB, "R11");
    idle(2, 1'b1, 1'b0, "R11");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule